// File: doc/BRIEF.md
# Receive Frame Transfer Sequencer

This block moves each received frame from the media access layer into a system-side buffer, one byte per clock. Each output byte carries a 3-bit transfer code that marks it as the start of a frame, a body byte, the end of the body, the frame-status summary, or an idle filler. An odd parity bit goes with every byte. Upstream logic presents per-byte strobes for frame start, body data, frame end and each received status symbol (S or R). It also presents the flush and next-station-address flags. Address recognition and CRC checking are done elsewhere.

A frame always leaves in the same order: start, body bytes, end, then one status byte. Filler may appear anywhere between these transfers. The status byte holds a 5-bit field built one symbol at a time. The first symbol lands in the highest bit. The system side can cut a frame short with a one-cycle abort. The block then closes the frame at once with an end transfer and a status transfer, both marked as errors.

Top module: `rx_xfer_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are code FILLER, byte 0x00 and parity 1, and the sequencer returns to idle.
- R2: Every transfer appears one clock after its strobe. A `rx_start` in idle gives START_DATA carrying `rx_byte`. A `rx_data` inside a frame gives DATA carrying `rx_byte`.
- R3: Any cycle without an accepted strobe gives FILLER with byte 0x00. Data, end, done and status strobes in idle are ignored.
- R4: A `rx_end` inside a frame gives END_DATA. Its byte has bit 7 equal to `flush_flag` sampled with the strobe, bit 6 equal to 0, and bits 5:0 equal to 0.
- R5: Status symbols accepted after END_DATA fill a 5-bit field from bit 4 down to bit 0, with S=1 and R=0. Bits not filled read 0. Symbols after the fifth are ignored.
- R6: A `rx_fs_done` after END_DATA gives FRAME_STATUS on the next clock. A symbol strobed in the same cycle is included. The byte is laid out as bit 7 = F, bit 6 = error, bit 5 = 0 and bits 4:0 = the field. The block then returns to idle.
- R7: The F bit of FRAME_STATUS equals the F bit of END_DATA. It is forced to 1 only if both `sec_nsa` and `nsa_flush_en` are high with `rx_fs_done`. F never goes from 1 to 0.
- R8: A `sys_abort` high for one cycle inside a frame overrides any data or end strobe in that cycle. Next comes END_DATA with bit 6 = 1 and bit 7 = `flush_flag`. Then comes FRAME_STATUS with bit 6 = 1, field 0 and the same F bit. Then FILLER. Abort outside a frame has no effect.
- R9: `xfer_par` makes the count of ones over `xfer_byte` and itself odd on every cycle.
- R10: The transfer codes are FILLER=000, START_DATA=001, DATA=010, END_DATA=011 and FRAME_STATUS=101. Codes 100, 110 and 111 are never driven; 100 is reserved and counts as filler.
- R11: A `rx_start` inside a frame or during the status phase is ignored. The cycle gives FILLER unless another strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | 8 | Received byte for start and data strobes |
| rx_start | input | 1 | First byte of a frame is on `rx_byte` |
| rx_data | input | 1 | Body byte is on `rx_byte` |
| rx_end | input | 1 | Frame body has ended |
| rx_sym_vld | input | 1 | A status symbol is present |
| rx_sym_s | input | 1 | Status symbol value: 1 = S, 0 = R |
| rx_fs_done | input | 1 | Status field complete |
| sys_abort | input | 1 | System side abort request |
| flush_flag | input | 1 | Flush indication for the current frame |
| sec_nsa | input | 1 | Frame is a secondary next-station-addressed frame |
| nsa_flush_en | input | 1 | Flushing of such frames is enabled |
| xfer_byte | output | 8 | Transfer byte |
| xfer_code | output | 3 | Transfer code |
| xfer_par | output | 1 | Odd parity over `xfer_byte` |

## Verification
The sequence table drives full frames with different body lengths and internal filler gaps. Stray strobes are placed in idle and in every phase, which shows that the order is enforced and not just passed through. Status-symbol runs shorter than five, exactly five and longer than five show the fill direction, the padding and the saturation. Flag mixes at end and done show when F may rise and that it never falls. Aborts are placed together with a data strobe, with and without flush, and in idle, which separates an abort that takes over the frame from one that is ignored. A reset in the middle of a frame is checked on its own.

// File: rtl/rxseq_pkg.sv
// Shared types for the receive transfer sequencer.
// Assumes a 3-bit transfer code and a 2-bit sequencer state.
package rxseq_pkg;
    typedef enum logic [2:0] {
        XC_FILL  = 3'b000,
        XC_START = 3'b001,
        XC_DATA  = 3'b010,
        XC_END   = 3'b011,
        XC_STAT  = 3'b101
    } xfer_code_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FRAME = 2'd1,
        SQ_STAT  = 2'd2,
        SQ_ABT   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/rxseq_fs_collect.sv
// Builds the frame-status field one symbol at a time, starting at the top bit.
// Assumes the caller feeds symbols only during the status phase and clears the
// field between frames. fs_nxt already includes a symbol strobed this cycle.
module rxseq_fs_collect #(
    parameter int FS_SYMS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               sym_vld,
    input  logic               sym_s,
    output logic [FS_SYMS-1:0] fs_nxt
);
    localparam int CW = $clog2(FS_SYMS + 1);

    logic [FS_SYMS-1:0] fs_q;
    logic [CW-1:0]      cnt_q;
    logic               ins;

    // accept a symbol only while the field still has room
    assign ins = sym_vld && (cnt_q < CW'(FS_SYMS));

    // place the incoming symbol at the next free position, counting downward
    for (genvar k = 0; k < FS_SYMS; k++) begin : g_bit
        assign fs_nxt[k] = (ins && (cnt_q == CW'(FS_SYMS - 1 - k))) ? sym_s : fs_q[k];
    end

    // hold the field and its fill count
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fs_q  <= '0;
            cnt_q <= '0;
        end else begin
            fs_q  <= fs_nxt;
            cnt_q <= cnt_q + CW'(ins);
        end
    end
endmodule

// File: rtl/rxseq_ctrl.sv
// Sequencer state machine: idle -> frame -> status (or abort) -> idle.
// Works out the code and byte for the next cycle. Enforces the transfer order
// and keeps the flush bit from END_DATA so it can go into FRAME_STATUS.
module rxseq_ctrl
    import rxseq_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int FS_SYMS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BYTE_W-1:0]  din,
    input  logic               start_i,
    input  logic               data_i,
    input  logic               end_i,
    input  logic               done_i,
    input  logic               sym_vld_i,
    input  logic               abort_i,
    input  logic               flush_i,
    input  logic               sec_nsa_i,
    input  logic               nsa_en_i,
    input  logic [FS_SYMS-1:0] fs_nxt,
    output logic               fs_clr,
    output logic               fs_feed,
    output xfer_code_e         nxt_code,
    output logic [BYTE_W-1:0]  nxt_byte
);
    localparam int F_BIT   = BYTE_W - 1;
    localparam int ERR_BIT = BYTE_W - 2;

    seq_state_e st_q, st_n;
    logic       f_q, f_n;

    // next-state and next-output decode
    always_comb begin
        st_n     = st_q;
        f_n      = f_q;
        fs_clr   = 1'b0;
        fs_feed  = 1'b0;
        nxt_code = XC_FILL;
        nxt_byte = '0;
        case (st_q)
            SQ_IDLE: begin
                if (start_i) begin
                    nxt_code = XC_START;
                    nxt_byte = din;
                    fs_clr   = 1'b1;
                    st_n     = SQ_FRAME;
                end
            end
            SQ_FRAME: begin
                if (abort_i) begin
                    nxt_code         = XC_END;
                    nxt_byte[F_BIT]  = flush_i;
                    nxt_byte[ERR_BIT] = 1'b1;
                    f_n              = flush_i;
                    st_n             = SQ_ABT;
                end else if (end_i) begin
                    nxt_code        = XC_END;
                    nxt_byte[F_BIT] = flush_i;
                    f_n             = flush_i;
                    st_n            = SQ_STAT;
                end else if (data_i) begin
                    nxt_code = XC_DATA;
                    nxt_byte = din;
                end
            end
            SQ_STAT: begin
                fs_feed = sym_vld_i;
                if (done_i) begin
                    nxt_code                = XC_STAT;
                    nxt_byte[FS_SYMS-1:0]   = fs_nxt;
                    nxt_byte[F_BIT]         = f_q | (sec_nsa_i & nsa_en_i);
                    fs_clr                  = 1'b1;
                    st_n                    = SQ_IDLE;
                end
            end
            default: begin
                nxt_code          = XC_STAT;
                nxt_byte[F_BIT]   = f_q;
                nxt_byte[ERR_BIT] = 1'b1;
                st_n              = SQ_IDLE;
            end
        endcase
    end

    // state and held flush bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SQ_IDLE;
            f_q  <= 1'b0;
        end else begin
            st_q <= st_n;
            f_q  <= f_n;
        end
    end
endmodule

// File: rtl/rxseq_parity.sv
// Odd parity generator: the output makes the total count of ones odd.
module rxseq_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] d,
    output logic         p
);
    // odd parity over the data word
    assign p = ~(^d);
endmodule

// File: rtl/rx_xfer_seq.sv
// Receive frame transfer sequencer top. It registers the code, the byte and
// the odd parity from the sequencer. Assumes strobes are single-cycle and
// synchronous to clk. All outputs change one clock after the strobe.
module rx_xfer_seq
    import rxseq_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int FS_SYMS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_start,
    input  logic              rx_data,
    input  logic              rx_end,
    input  logic              rx_sym_vld,
    input  logic              rx_sym_s,
    input  logic              rx_fs_done,
    input  logic              sys_abort,
    input  logic              flush_flag,
    input  logic              sec_nsa,
    input  logic              nsa_flush_en,
    output logic [BYTE_W-1:0] xfer_byte,
    output logic [2:0]        xfer_code,
    output logic              xfer_par
);
    logic [FS_SYMS-1:0] fs_nxt;
    logic               fs_clr, fs_feed, par_nxt;
    xfer_code_e         nxt_code;
    logic [BYTE_W-1:0]  nxt_byte;

    rxseq_fs_collect #(.FS_SYMS(FS_SYMS)) u_fs (
        .clk(clk), .rst_n(rst_n), .clr(fs_clr),
        .sym_vld(fs_feed), .sym_s(rx_sym_s), .fs_nxt(fs_nxt)
    );

    rxseq_ctrl #(.BYTE_W(BYTE_W), .FS_SYMS(FS_SYMS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .din(rx_byte),
        .start_i(rx_start), .data_i(rx_data), .end_i(rx_end),
        .done_i(rx_fs_done), .sym_vld_i(rx_sym_vld), .abort_i(sys_abort),
        .flush_i(flush_flag), .sec_nsa_i(sec_nsa), .nsa_en_i(nsa_flush_en),
        .fs_nxt(fs_nxt), .fs_clr(fs_clr), .fs_feed(fs_feed),
        .nxt_code(nxt_code), .nxt_byte(nxt_byte)
    );

    rxseq_parity #(.W(BYTE_W)) u_par (.d(nxt_byte), .p(par_nxt));

    // output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_byte <= '0;
            xfer_code <= XC_FILL;
            xfer_par  <= 1'b1;
        end else begin
            xfer_byte <= nxt_byte;
            xfer_code <= nxt_code;
            xfer_par  <= par_nxt;
        end
    end
endmodule

// File: rtl/rxseq_chk.sv
// Protocol checker for rx_xfer_seq. It watches the ports only and rebuilds
// the frame phase from the transfer codes seen so far.
module rxseq_chk
    import rxseq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sys_abort,
    input logic              rx_fs_done,
    input logic [BYTE_W-1:0] xfer_byte,
    input logic [2:0]        xfer_code,
    input logic              xfer_par
);
    logic open_q, open_now, pend_q, pend_now, f_hold;

    // a frame body is open after START until END
    assign open_now = (xfer_code == XC_START) || (xfer_code == XC_DATA) ||
                      (open_q && (xfer_code == XC_FILL));
    // a status transfer is owed after END until STAT
    assign pend_now = (xfer_code == XC_END) || (pend_q && (xfer_code != XC_STAT));

    // track phase and the flush bit seen at END
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            pend_q <= 1'b0;
            f_hold <= 1'b0;
        end else begin
            open_q <= open_now;
            pend_q <= pend_now;
            if (xfer_code == XC_END) f_hold <= xfer_byte[BYTE_W-1];
        end
    end

    // R9
    par_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (^{xfer_byte, xfer_par}) == 1'b1);
    // R10
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_code inside {XC_FILL, XC_START, XC_DATA, XC_END, XC_STAT});
    // R2
    data_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_code == XC_DATA) |-> open_q);
    // R11
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_code == XC_START) |-> (!open_q && !pend_q));
    // R8
    abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_now && sys_abort) |=> (xfer_code == XC_END && xfer_byte[BYTE_W-2]));
    // R8
    abort_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_code == XC_END && xfer_byte[BYTE_W-2]) |=> (xfer_code == XC_STAT && xfer_byte[BYTE_W-2]));
    // R6
    done_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_now && rx_fs_done) |=> (xfer_code == XC_STAT));
    // R7
    f_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_code == XC_STAT && f_hold) |-> xfer_byte[BYTE_W-1]);
endmodule

bind rx_xfer_seq rxseq_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sys_abort(sys_abort), .rx_fs_done(rx_fs_done),
    .xfer_byte(xfer_byte), .xfer_code(xfer_code), .xfer_par(xfer_par)
);

// File: tb/tb_rx_xfer_seq.sv
module tb_rx_xfer_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_start = 0, rx_data = 0, rx_end = 0, rx_sym_vld = 0, rx_sym_s = 0;
    logic       rx_fs_done = 0, sys_abort = 0, flush_flag = 0, sec_nsa = 0, nsa_flush_en = 0;
    logic [7:0] xfer_byte;
    logic [2:0] xfer_code;
    logic       xfer_par;
    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    rx_xfer_seq dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_start(rx_start),
        .rx_data(rx_data), .rx_end(rx_end), .rx_sym_vld(rx_sym_vld),
        .rx_sym_s(rx_sym_s), .rx_fs_done(rx_fs_done), .sys_abort(sys_abort),
        .flush_flag(flush_flag), .sec_nsa(sec_nsa), .nsa_flush_en(nsa_flush_en),
        .xfer_byte(xfer_byte), .xfer_code(xfer_code), .xfer_par(xfer_par)
    );

    always #5 clk = ~clk;

    // vector: req[32:29] flags[28:19]={st,dv,en,sv,ss,dn,ab,fl,sn,fe}
    //         din[18:11] exp_code[10:8] exp_byte[7:0]
    localparam int NV = 35;
    localparam logic [32:0] VEC [NV] = '{
        {4'd3,  10'b0000000000, 8'h00, 3'b000, 8'h00}, // R3 idle filler
        {4'd3,  10'b0100000000, 8'h55, 3'b000, 8'h00}, // R3 data in idle ignored
        {4'd2,  10'b1000000000, 8'h50, 3'b001, 8'h50}, // R2 start
        {4'd2,  10'b0100000000, 8'hA3, 3'b010, 8'hA3}, // R2 data
        {4'd3,  10'b0000000000, 8'h00, 3'b000, 8'h00}, // R3 gap in frame
        {4'd11, 10'b1000000000, 8'h77, 3'b000, 8'h00}, // R11 start in frame
        {4'd2,  10'b0100000000, 8'h0F, 3'b010, 8'h0F}, // R2 data
        {4'd4,  10'b0010000000, 8'h00, 3'b011, 8'h00}, // R4 end, no flush
        {4'd5,  10'b0001100000, 8'h00, 3'b000, 8'h00}, // R5 S
        {4'd5,  10'b0001000000, 8'h00, 3'b000, 8'h00}, // R5 R
        {4'd7,  10'b0001110011, 8'h00, 3'b101, 8'h94}, // R7 S with done, F rises
        {4'd3,  10'b0000000000, 8'h00, 3'b000, 8'h00}, // R3
        {4'd2,  10'b1000000000, 8'h41, 3'b001, 8'h41}, // R2 start
        {4'd4,  10'b0010000100, 8'h00, 3'b011, 8'h80}, // R4 end with flush
        {4'd5,  10'b0001100000, 8'h00, 3'b000, 8'h00}, // R5 S
        {4'd5,  10'b0001100000, 8'h00, 3'b000, 8'h00}, // R5 S
        {4'd5,  10'b0001100000, 8'h00, 3'b000, 8'h00}, // R5 S
        {4'd5,  10'b0001000000, 8'h00, 3'b000, 8'h00}, // R5 R
        {4'd5,  10'b0001100000, 8'h00, 3'b000, 8'h00}, // R5 S (fifth)
        {4'd5,  10'b0001100000, 8'h00, 3'b000, 8'h00}, // R5 sixth ignored
        {4'd6,  10'b0000010000, 8'h00, 3'b101, 8'h9D}, // R6 status, F held
        {4'd2,  10'b1000000000, 8'h00, 3'b001, 8'h00}, // R2 start
        {4'd4,  10'b0010000000, 8'h00, 3'b011, 8'h00}, // R4 end
        {4'd11, 10'b1001001000, 8'h12, 3'b000, 8'h00}, // R11 start+abort in status
        {4'd7,  10'b0000010010, 8'h00, 3'b101, 8'h00}, // R7 one flag only, F stays 0
        {4'd2,  10'b1000000000, 8'h3C, 3'b001, 8'h3C}, // R2 start
        {4'd8,  10'b0100001000, 8'h81, 3'b011, 8'h40}, // R8 abort beats data
        {4'd8,  10'b0100000000, 8'h99, 3'b101, 8'h40}, // R8 error status
        {4'd3,  10'b0010000000, 8'h00, 3'b000, 8'h00}, // R3 end in idle ignored
        {4'd8,  10'b0000001000, 8'h00, 3'b000, 8'h00}, // R8 abort in idle ignored
        {4'd2,  10'b1000000000, 8'hFF, 3'b001, 8'hFF}, // R2 start
        {4'd8,  10'b0000001100, 8'h00, 3'b011, 8'hC0}, // R8 abort with flush
        {4'd8,  10'b0001100000, 8'h00, 3'b101, 8'hC0}, // R8 status keeps F
        {4'd3,  10'b0000010000, 8'h00, 3'b000, 8'h00}, // R3 done in idle ignored
        {4'd10, 10'b0000000000, 8'h00, 3'b000, 8'h00}  // R10 filler code 000
    };

    task automatic drive(input logic [9:0] f, input logic [7:0] d);
        {rx_start, rx_data, rx_end, rx_sym_vld, rx_sym_s,
         rx_fs_done, sys_abort, flush_flag, sec_nsa, nsa_flush_en} = f;
        rx_byte = d;
    endtask

    task automatic check_out(input string req, input logic [2:0] ec, input logic [7:0] eb);
        checks += 3;
        if (xfer_code !== ec) begin
            fails++;
            $display("FAIL %s code actual=%b expected=%b", req, xfer_code, ec);
        end
        if (xfer_byte !== eb) begin
            fails++;
            $display("FAIL %s byte actual=%h expected=%h", req, xfer_byte, eb);
        end
        // R9 odd parity expected from the requirement
        if (xfer_par !== ~(^eb)) begin
            fails++;
            $display("FAIL R9 parity actual=%b expected=%b", xfer_par, ~(^eb));
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_out("R1", 3'b000, 8'h00);          // R1 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][28:19], VEC[i][18:11]);
            @(negedge clk);
            check_out($sformatf("R%0d vec%0d", VEC[i][32:29], i), VEC[i][10:8], VEC[i][7:0]);
        end
        // R1 reset in the middle of a frame
        drive(10'b1000000000, 8'h6B);
        @(negedge clk);
        check_out("R2", 3'b001, 8'h6B);
        drive(10'b0100000000, 8'h6C);
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R1", 3'b000, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R3", 3'b000, 8'h00);          // R3 data after reset: idle
        drive(10'b0, 8'h00);
        @(negedge clk);
        check_out("R3", 3'b000, 8'h00);
        finish_run();
    end

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule